// File: doc/BRIEF.md
# Eight-Mode Shift and Rotate Register

This block is a word-wide storage register whose next contents are picked on every rising clock edge by a three-bit operation code. Eight operations are available: keep the word, take a new word from the parallel input, zero the word, invert every bit, and move the word one place toward either end, either dropping the bit that falls off the end and filling with zero, or carrying it round to the other end.

The block is meant to be placed in a datapath where a controller issues one operation code per cycle. The stored word drives the output directly from flip-flops, so a downstream stage sees the result one cycle after the code was presented. A synchronous active-high reset forces the word to zero and overrides any operation code in the same cycle. The width defaults to eight bits and is a parameter.

Top module: `mode_shift_reg`

## Requirements
- R1: The output `dout` is the stored word itself, driven from flip-flops; it changes only on a rising edge of `clk` and has width `W` (default 8).
- R2: When `rst` is 1 at a rising edge, the stored word becomes all zeros whatever `sel` and `din` are; reset takes precedence over every operation code.
- R3: With `sel` = 0 (hold) the stored word is unchanged after the edge.
- R4: With `sel` = 1 (load) the stored word becomes the value on `din` at the edge.
- R5: With `sel` = 2 (clear) the stored word becomes all zeros.
- R6: With `sel` = 3 (invert) every bit of the stored word is complemented.
- R7: With `sel` = 4 (logical right move) bit i takes the old bit i+1, the most significant bit becomes 0 and the old bit 0 is lost.
- R8: With `sel` = 5 (right rotate) bit i takes the old bit i+1 and the most significant bit takes the old bit 0.
- R9: With `sel` = 6 (logical left move) bit i takes the old bit i-1, bit 0 becomes 0 and the old most significant bit is lost.
- R10: With `sel` = 7 (left rotate) bit i takes the old bit i-1 and bit 0 takes the old most significant bit.
- R11: For every `sel` value other than 1, the value on `din` has no effect on the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| sel | input | 3 | Operation code, 0 to 7 as listed in the requirements |
| din | input | W | Parallel word taken when `sel` = 1 |
| dout | output | W | Current stored word |

## Verification
Reset and an operation code always arrive together, since `sel` is never idle: the interesting overlap is a reset cycle that coincides with a load of a non-zero word or an invert of a zero word, both of which would otherwise leave a non-zero result. The bench asserts `rst` on a random fraction of cycles while `sel` and `din` keep taking random values, and adds directed cycles with reset during load of all ones and during invert; each is judged by the output being exactly zero one edge later, after which the reference model restarts from zero.

// File: rtl/mode_shift_reg_pkg.sv
package mode_shift_reg_pkg;

  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_LOAD   = 3'd1,
    OP_CLEAR  = 3'd2,
    OP_INVERT = 3'd3,
    OP_SHR    = 3'd4,
    OP_ROR    = 3'd5,
    OP_SHL    = 3'd6,
    OP_ROL    = 3'd7
  } op_e;

endpackage

// File: rtl/mode_shift_reg_next.sv
module mode_shift_reg_next
  import mode_shift_reg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  input  op_e          op,
  output logic [W-1:0] nxt
);

  // One slice per bit; the end slices choose between zero fill and wrap.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_hi;
    logic from_lo;
    logic bit_n;

    if (i == W - 1) begin : g_top
      assign from_hi = (op == OP_ROR) ? cur[0] : 1'b0;
    end else begin : g_mid_hi
      assign from_hi = cur[i+1];
    end

    if (i == 0) begin : g_bot
      assign from_lo = (op == OP_ROL) ? cur[W-1] : 1'b0;
    end else begin : g_mid_lo
      assign from_lo = cur[i-1];
    end

    always_comb begin
      unique case (op)
        OP_HOLD:          bit_n = cur[i];
        OP_LOAD:          bit_n = din[i];
        OP_CLEAR:         bit_n = 1'b0;
        OP_INVERT:        bit_n = ~cur[i];
        OP_SHR, OP_ROR:   bit_n = from_hi;
        OP_SHL, OP_ROL:   bit_n = from_lo;
        default:          bit_n = cur[i];
      endcase
    end

    assign nxt[i] = bit_n;
  end

endmodule

// File: rtl/mode_shift_reg_store.sv
module mode_shift_reg_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/mode_shift_reg.sv
module mode_shift_reg
  import mode_shift_reg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  op_e          op;
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  assign op = op_e'(sel);

  mode_shift_reg_next #(.W(W)) u_next (
    .cur (word_q),
    .din (din),
    .op  (op),
    .nxt (word_d)
  );

  mode_shift_reg_store #(.W(W)) u_store (
    .clk (clk),
    .rst (rst),
    .d   (word_d),
    .q   (word_q)
  );

  assign dout = word_q;

endmodule

// File: rtl/mode_shift_reg_chk.sv
module mode_shift_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   sel,
  input logic [W-1:0] din,
  input logic [W-1:0] dout
);

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (dout == '0)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0) |=> $stable(dout)); // R3

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd1) |=> (dout == $past(din))); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd2) |=> (dout == '0)); // R5

  AST_INVERT_ALL: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd3) |=> (dout == ~$past(dout))); // R6

  AST_SHR_FILL: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd4) |=> (dout == {1'b0, $past(dout[W-1:1])})); // R7

  AST_ROR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd5) |=> (dout == {$past(dout[0]), $past(dout[W-1:1])})); // R8

  AST_SHL_FILL: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd6) |=> (dout == {$past(dout[W-2:0]), 1'b0})); // R9

  AST_ROL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd7) |=> (dout == {$past(dout[W-2:0]), $past(dout[W-1])})); // R10

  AST_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
    (sel[2] && sel[0]) |=> ($countones(dout) == $countones($past(dout)))); // R8 R10

endmodule

bind mode_shift_reg mode_shift_reg_chk #(.W(W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .sel  (sel),
  .din  (din),
  .dout (dout)
);

// File: tb/mode_shift_reg_test.sv
module mode_shift_reg_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [2:0]   sel;
  logic [W-1:0] din;
  logic [W-1:0] dout;

  int n_vec  = 0;
  int n_fail = 0;
  logic [W-1:0] model;

  always #4 clk = ~clk;

  mode_shift_reg #(.W(W)) uut (
    .clk (clk), .rst (rst), .sel (sel), .din (din), .dout (dout)
  );

  function automatic logic [W-1:0] ref_next(logic [W-1:0] c, logic [2:0] s,
                                            logic [W-1:0] d, logic r);
    if (r) return '0;
    case (s)
      3'd0: return c;
      3'd1: return d;
      3'd2: return '0;
      3'd3: return ~c;
      3'd4: return c >> 1;
      3'd5: return {c[0], c[W-1:1]};
      3'd6: return c << 1;
      default: return {c[W-2:0], c[W-1]};
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] s, logic r);
    if (r) return "R2";
    case (s)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(logic [W-1:0] exp, string tag);
    n_vec++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%h expected=%h", tag, dout, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns after the rising edge.
  task automatic step(logic r, logic [2:0] s, logic [W-1:0] d, string tag);
    @(negedge clk);
    rst = r; sel = s; din = d;
    model = ref_next(model, s, d, r);
    @(posedge clk);
    #1;
    check(model, tag);
  endtask

  initial begin
    int unsigned seed = 32'd1998;
    void'($urandom(seed));
    rst = 1'b1; sel = 3'd1; din = 8'hFF; model = '0;
    @(posedge clk); #1;
    check('0, "R1");                       // reset state
    @(negedge clk);
    // R1: output changes only at the edge, not when inputs move mid-cycle
    rst = 1'b0; sel = 3'd1; din = 8'hA5;
    #2; check('0, "R1");
    @(posedge clk); #1; model = 8'hA5; check(model, "R4");

    // Directed corners
    step(0, 3'd4, 8'hFF, "R7");  // 0x52
    step(0, 3'd1, 8'h81, "R4");
    step(0, 3'd5, 8'h00, "R8");  // bit0 wraps to top
    step(0, 3'd7, 8'h00, "R10"); // top wraps to bit0
    step(0, 3'd6, 8'hFF, "R9");  // top dropped
    step(0, 3'd1, 8'h80, "R4");
    step(0, 3'd4, 8'h55, "R7");
    step(0, 3'd2, 8'hFF, "R5");
    step(0, 3'd3, 8'h12, "R6");  // becomes 0xFF
    step(0, 3'd0, 8'h00, "R11"); // din changes under hold
    step(0, 3'd0, 8'h3C, "R11");
    step(0, 3'd3, 8'hFF, "R11");
    step(1, 3'd1, 8'hFF, "R2");  // reset against load of all ones
    step(0, 3'd3, 8'h00, "R6");
    step(1, 3'd3, 8'h00, "R2");  // reset against invert of zero
    step(0, 3'd1, 8'h01, "R4");
    step(0, 3'd6, 8'hFF, "R9");  // 0 fills bit 0

    // Constrained random: reset about one cycle in sixteen
    for (int i = 0; i < 3000; i++) begin
      logic r;
      logic [2:0] s;
      r = ($urandom % 16) == 0;
      s = 3'($urandom);
      step(r, s, W'($urandom), (s != 3'd1 && !r) ? {tag_of(s, r), " R11"} : tag_of(s, r));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule